// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides how deeply the device sleeps once the CPU has executed its idle instruction, and it decides when the device wakes. Two software-set select bits pick the sleep depth: a power-down select and a halt-versus-standby select. A hard-wired disable input can rule out the two deep modes for good. There are three sleep depths. Plain idle stops only the CPU clock. Standby also stops the peripheral clock but keeps the timer and the oscillator running. Halt stops everything, including the oscillator.

Each depth has its own set of wake sources. Idle wakes on any enabled interrupt request. Standby wakes on the three external interrupts or the timer interrupt. Halt wakes only on the external interrupts. Hardware reset returns the block to the run state from any depth. A wake from halt first turns the oscillator back on. The CPU clock comes back only after a stabilization count that software can configure. Every completed wake gives a one-cycle pulse. The controller's own clock, `clk`, is an always-on reference that is not subject to the enables this block produces.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is run: `cpu_clk_en`, `per_clk_en`, `tmr_clk_en` and `osc_en` are all 1 and `wake_pulse` is 0. This holds from whatever depth the block was in.
- R2: In run, an `idle_exec` strobe with `pwrdn_sel`=1 and `lpm_disable`=0 enters standby when `halt_sel`=0 and halt when `halt_sel`=1. The new clock enables are visible in the cycle after the edge that sampled the strobe.
- R3: In run, an `idle_exec` strobe with `pwrdn_sel`=0, or with `lpm_disable`=1, enters plain idle whatever `halt_sel` is.
- R4: In idle, the enables are cpu=0, per=1, tmr=1, osc=1. Any single line among `irq_ext[2:0]`, `irq_tmr` and `irq_gen` wakes the block to run.
- R5: In standby, the enables are cpu=0, per=0, tmr=1, osc=1. Any bit of `irq_ext` or `irq_tmr` wakes the block. `irq_gen` alone has no effect.
- R6: In halt, all four enables are 0. Only a bit of `irq_ext` wakes the block. `irq_tmr` and `irq_gen` have no effect.
- R7: A wake from halt gives exactly `stab_count`+1 cycles with osc=1 and cpu=per=tmr=0. After those cycles the block is in run. `stab_count` is sampled at the wake edge, and later changes to it do not matter.
- R8: `wake_pulse` is high for exactly one cycle: the first run cycle after a wake from idle or standby, or after the stabilization count ends. It is never high after reset alone.
- R9: `idle_exec` is ignored in every state other than run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| idle_exec | input | 1 | One-cycle strobe: the CPU executed the idle instruction |
| pwrdn_sel | input | 1 | 1 allows a deep (standby or halt) mode |
| halt_sel | input | 1 | Deep mode pick: 0 standby, 1 halt |
| lpm_disable | input | 1 | Hard-wired option that forbids deep modes |
| irq_ext | input | EXT_N (3) | External interrupt requests |
| irq_tmr | input | 1 | Timer interrupt request |
| irq_gen | input | 1 | Any other enabled interrupt request |
| stab_count | input | STAB_W (16) | Oscillator stabilization cycles after a halt wake |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-cycle pulse on a completed wake |

## Verification
Each sleep depth is offered every wake line in turn: the general request alone, the timer request alone, and each external bit. This separates the three wake-source sets, and in particular shows that a timer request ends standby but not halt. The select bits are crossed with the disable input to show that only one of the four combinations reaches halt and that the disable forces plain idle. Halt wakes are tried with a stabilization count of zero, with small random counts and with a count of several hundred that changes right after the wake edge, which pins the window length to the value sampled at the edge. Random runs mix strobes given during sleep and resets given in every state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int DEF_EXT_N  = 3;
    localparam int DEF_STAB_W = 16;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_IDLE = 3'd1,
        ST_STBY = 3'd2,
        ST_HALT = 3'd3,
        ST_WARM = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic tmr;
        logic osc;
    } clk_en_t;

    // Depth chosen by the idle instruction from the select bits.
    function automatic pm_state_e pick_sleep(input logic pwrdn,
                                             input logic halt,
                                             input logic dis);
        if (!pwrdn || dis)
            return ST_IDLE;
        return halt ? ST_HALT : ST_STBY;
    endfunction

    // Clock enables held in each state.
    function automatic clk_en_t gates_for(input pm_state_e st);
        clk_en_t g;
        case (st)
            ST_RUN:  g = '{cpu: 1'b1, per: 1'b1, tmr: 1'b1, osc: 1'b1};
            ST_IDLE: g = '{cpu: 1'b0, per: 1'b1, tmr: 1'b1, osc: 1'b1};
            ST_STBY: g = '{cpu: 1'b0, per: 1'b0, tmr: 1'b1, osc: 1'b1};
            ST_HALT: g = '{cpu: 1'b0, per: 1'b0, tmr: 1'b0, osc: 1'b0};
            ST_WARM: g = '{cpu: 1'b0, per: 1'b0, tmr: 1'b0, osc: 1'b1};
            default: g = '{cpu: 1'b1, per: 1'b1, tmr: 1'b1, osc: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int EXT_N = DEF_EXT_N
) (
    input  pm_state_e        state,
    input  logic [EXT_N-1:0] irq_ext,
    input  logic             irq_tmr,
    input  logic             irq_gen,
    output logic             wake
);

    logic any_ext;

    // OR tree over the external lines, sized by EXT_N.
    logic [EXT_N:0] ext_chain;
    assign ext_chain[0] = 1'b0;
    for (genvar i = 0; i < EXT_N; i++) begin : g_ext_or
        assign ext_chain[i+1] = ext_chain[i] | irq_ext[i];
    end
    assign any_ext = ext_chain[EXT_N];

    always_comb begin
        case (state)
            ST_IDLE: wake = any_ext | irq_tmr | irq_gen;
            ST_STBY: wake = any_ext | irq_tmr;
            ST_HALT: wake = any_ext;
            default: wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
    parameter int STAB_W = lpm_pkg::DEF_STAB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAB_W-1:0] load_val,
    input  logic              active,
    output logic              done
);

    logic [STAB_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (active && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R7: the window shrinks by one each warm-up cycle
    a_r7_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load && active && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: a load captures the sampled count
    a_r7_load_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
    import lpm_pkg::*;
(
    input  pm_state_e state,
    output clk_en_t   gates
);

    always_comb gates = gates_for(state);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int EXT_N  = DEF_EXT_N,
    parameter int STAB_W = DEF_STAB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle_exec,
    input  logic              pwrdn_sel,
    input  logic              halt_sel,
    input  logic              lpm_disable,
    input  logic [EXT_N-1:0]  irq_ext,
    input  logic              irq_tmr,
    input  logic              irq_gen,
    input  logic [STAB_W-1:0] stab_count,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              tmr_clk_en,
    output logic              osc_en,
    output logic              wake_pulse
);

    pm_state_e state_q, state_d;
    logic      wake_q, wake_d;
    logic      wake;
    logic      stab_load;
    logic      stab_done;
    clk_en_t   gates;

    lpm_wake_qual #(.EXT_N(EXT_N)) u_qual (
        .state   (state_q),
        .irq_ext (irq_ext),
        .irq_tmr (irq_tmr),
        .irq_gen (irq_gen),
        .wake    (wake)
    );

    lpm_stab_timer #(.STAB_W(STAB_W)) u_stab (
        .clk      (clk),
        .rst      (rst),
        .load     (stab_load),
        .load_val (stab_count),
        .active   (state_q == ST_WARM),
        .done     (stab_done)
    );

    lpm_gate_dec u_gate (
        .state (state_q),
        .gates (gates)
    );

    always_comb begin
        state_d   = state_q;
        wake_d    = 1'b0;
        stab_load = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (idle_exec)
                    state_d = pick_sleep(pwrdn_sel, halt_sel, lpm_disable);
            end
            ST_IDLE, ST_STBY: begin
                if (wake) begin
                    state_d = ST_RUN;
                    wake_d  = 1'b1;
                end
            end
            ST_HALT: begin
                if (wake) begin
                    state_d   = ST_WARM;
                    stab_load = 1'b1;
                end
            end
            ST_WARM: begin
                if (stab_done) begin
                    state_d = ST_RUN;
                    wake_d  = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    assign cpu_clk_en = gates.cpu;
    assign per_clk_en = gates.per;
    assign tmr_clk_en = gates.tmr;
    assign osc_en     = gates.osc;
    assign wake_pulse = wake_q;

    // R2: a deep request with halt picked lands in halt
    a_r2_halt_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && idle_exec && pwrdn_sel && !lpm_disable && halt_sel)
        |=> (state_q == ST_HALT));

    // R3: disable or no power-down gives plain idle
    a_r3_plain_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && idle_exec && (lpm_disable || !pwrdn_sel))
        |=> (state_q == ST_IDLE));

    // R6: without an external request halt is kept
    a_r6_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && irq_ext == '0) |=> (state_q == ST_HALT));

    // R5: timer runs only with the oscillator on
    a_r5_tmr_needs_osc: assert property (@(posedge clk) disable iff (rst)
        tmr_clk_en |-> osc_en);

    // R8: pulse lasts one cycle and sits in run
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    a_r8_pulse_in_run: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (state_q == ST_RUN && cpu_clk_en));

    // R9: no strobe moves a sleeping block except through wake
    a_r9_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STBY && !wake) |=> (state_q == ST_STBY));

endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;

    localparam int M_RUN  = 0;
    localparam int M_IDLE = 1;
    localparam int M_STBY = 2;
    localparam int M_HALT = 3;
    localparam int M_WARM = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idle_exec = 1'b0;
    logic        pwrdn_sel = 1'b0;
    logic        halt_sel = 1'b0;
    logic        lpm_disable = 1'b0;
    logic [2:0]  irq_ext = 3'b000;
    logic        irq_tmr = 1'b0;
    logic        irq_gen = 1'b0;
    logic [15:0] stab_count = 16'd0;
    logic        cpu_clk_en, per_clk_en, tmr_clk_en, osc_en, wake_pulse;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    int m_st = M_RUN;
    int m_cnt = 0;
    bit m_wp = 0;

    lpm_ctrl dut_i (
        .clk(clk), .rst(rst), .idle_exec(idle_exec), .pwrdn_sel(pwrdn_sel),
        .halt_sel(halt_sel), .lpm_disable(lpm_disable), .irq_ext(irq_ext),
        .irq_tmr(irq_tmr), .irq_gen(irq_gen), .stab_count(stab_count),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .tmr_clk_en(tmr_clk_en), .osc_en(osc_en), .wake_pulse(wake_pulse)
    );

    always #4 clk = ~clk;

    function automatic logic [3:0] exp_gates(input int st);
        case (st)
            M_RUN:   return 4'b1111;
            M_IDLE:  return 4'b0111;
            M_STBY:  return 4'b0011;
            M_HALT:  return 4'b0000;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic string req_of(input int st);
        case (st)
            M_RUN:   return "R1";
            M_IDLE:  return "R4";
            M_STBY:  return "R5";
            M_HALT:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_step();
        if (rst) begin
            m_st = M_RUN; m_wp = 0;
        end else begin
            m_wp = 0;
            case (m_st)
                M_RUN: if (idle_exec)
                    m_st = (pwrdn_sel && !lpm_disable) ? (halt_sel ? M_HALT : M_STBY) : M_IDLE;
                M_IDLE: if (|irq_ext || irq_tmr || irq_gen) begin m_st = M_RUN; m_wp = 1; end
                M_STBY: if (|irq_ext || irq_tmr) begin m_st = M_RUN; m_wp = 1; end
                M_HALT: if (|irq_ext) begin m_st = M_WARM; m_cnt = int'(stab_count); end
                default: if (m_cnt == 0) begin m_st = M_RUN; m_wp = 1; end
                         else m_cnt = m_cnt - 1;
            endcase
        end
    endtask

    // One clock: update the model at the edge, compare just after it.
    task automatic tick(input string req);
        logic [3:0] got;
        string r;
        @(posedge clk);
        model_step();
        #1;
        cycles++;
        r = (req == "") ? req_of(m_st) : req;
        got = {cpu_clk_en, per_clk_en, tmr_clk_en, osc_en};
        tests++;
        if (got !== exp_gates(m_st)) begin
            fails++;
            $display("FAIL %s clock enables got %b expected %b", r, got, exp_gates(m_st));
        end
        tests++;
        if (wake_pulse !== m_wp) begin
            fails++;
            $display("FAIL R8 wake_pulse got %0b expected %0b", wake_pulse, m_wp);
        end
    endtask

    task automatic clear_in();
        idle_exec = 0; irq_ext = 0; irq_tmr = 0; irq_gen = 0; rst = 0;
    endtask

    task automatic enter(input bit pd, input bit hs, input bit dis, input string req);
        pwrdn_sel = pd; halt_sel = hs; lpm_disable = dis; idle_exec = 1;
        tick(req);
        idle_exec = 0;
    endtask

    initial begin
        void'($urandom(32'h1A5C_0D3E));
        // R1 reset state
        rst = 1;
        repeat (3) tick("R1");
        clear_in();
        tick("R1");

        // R2 standby entry, R5 gen ignored, R9 strobe ignored, R5 timer wakes
        enter(1, 0, 0, "R2");
        tick("R5");
        irq_gen = 1; tick("R5"); irq_gen = 0;
        idle_exec = 1; pwrdn_sel = 1; halt_sel = 1; tick("R9"); idle_exec = 0;
        irq_tmr = 1; tick("R5"); irq_tmr = 0;
        tick("R8");

        // R2 halt entry, R6 timer and gen ignored, R7 zero count
        enter(1, 1, 0, "R2");
        irq_tmr = 1; irq_gen = 1; tick("R6"); tick("R6");
        irq_tmr = 0; irq_gen = 0;
        stab_count = 16'd0;
        irq_ext = 3'b100; tick("R6"); irq_ext = 0;
        tick("R7");
        tick("R8");

        // R3 disable forces idle, R4 gen wakes idle
        enter(1, 1, 1, "R3");
        tick("R4");
        irq_gen = 1; tick("R4"); irq_gen = 0;
        // R3 no power-down forces idle, R4 external wakes
        enter(0, 1, 0, "R3");
        irq_ext = 3'b001; tick("R4"); irq_ext = 0;

        // R7 long count sampled at the wake edge
        enter(1, 1, 0, "R2");
        stab_count = 16'd300;
        irq_ext = 3'b010; tick("R6"); irq_ext = 0;
        stab_count = 16'd5;
        repeat (301) tick("R7");
        tick("R8");

        // R1 reset out of halt
        enter(1, 1, 0, "R2");
        rst = 1; tick("R1"); rst = 0;
        tick("R1");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            rst         = ($urandom % 400) == 0;
            idle_exec   = ($urandom % 6) == 0;
            pwrdn_sel   = $urandom % 2;
            halt_sel    = $urandom % 2;
            lpm_disable = ($urandom % 4) == 0;
            irq_ext     = (($urandom % 12) == 0) ? 3'($urandom % 8) : 3'b000;
            irq_tmr     = ($urandom % 10) == 0;
            irq_gen     = ($urandom % 10) == 0;
            stab_count  = 16'($urandom % 16);
            tick("");
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule